// File: doc/BRIEF.md
# Cut-Through Transmit FIFO Start Controller

This block holds outgoing packets in a word-wide transmit FIFO and decides when the packet at the head may begin leaving on the serial link. A host-side writer pushes 32-bit words, each tagged with an end-of-packet flag. A link-side reader pulls words whenever the block shows it is sending. A 2-bit threshold field selects full store-and-forward or one of three cut-through start levels.

If the link asks for a word while the FIFO is empty in the middle of a packet, the block signals an abort. It rewinds to the first word of the packet and retries the packet in store-and-forward mode. Once the retry budget is used up, the packet is discarded and an error pulse is raised. Store-and-forward stays in force after an underrun until the threshold field is changed. It is also forced whenever the retry limit is zero.

The controller has three states. In `ST_WAIT` the head packet is buffered but not yet started. In `ST_SEND` words are offered to the link. In `ST_DROP` the rest of an abandoned packet is discarded. The transitions are:
- start: `ST_WAIT`→`ST_SEND`, when the start condition holds.
- finish: `ST_SEND`→`ST_WAIT`, when the end-of-packet word is popped.
- retry: `ST_SEND`→`ST_WAIT`, on an underrun with retries left.
- give-up: `ST_SEND`→`ST_DROP`, on an underrun with no retries left.
- flush: `ST_DROP`→`ST_WAIT`, when the end-of-packet word is discarded.

Top module: `tx_cut_ctl`

## Requirements
- R1: After reset, `wr_full`, `rd_valid`, `tx_busy`, `tx_abort` and `tx_drop` are all 0.
- R2: With `thr_sel` = 2'b00 (the reset setting), a packet never starts until its end-of-packet word has been written.
- R3: With `thr_sel` = 2'b11, 2'b10 or 2'b01, and no forced store-and-forward, a packet starts once 128, 256 or 432 words of it are buffered respectively. `tx_busy` rises on the clock edge after the word that reaches the level is written.
- R4: A packet whose end-of-packet word is buffered starts even when it is shorter than the threshold.
- R5: When `rd_ready` is 1 in `ST_SEND` and the FIFO holds no word, `tx_abort` pulses for that cycle and `tx_busy` drops. The next attempt resends the packet from its first word.
- R6: After an underrun, the next attempt waits for the end-of-packet word before starting.
- R7: Store-and-forward stays in force for later packets after an underrun, until `thr_sel` changes value.
- R8: While `retry_limit` is 0, every packet waits for its end-of-packet word, whatever `thr_sel` holds.
- R9: An underrun after `retry_limit` retries of a packet pulses both `tx_abort` and `tx_drop`. The remaining words of that packet, up to its end-of-packet word, are discarded unseen, and the next packet is delivered intact.
- R10: `wr_full` is 1 while 1024 words are held from the start of the head packet onward, and writes are then ignored. It clears once the head packet has been popped completely.
- R11: Words reach the link in write order, with `rd_eop` equal to the flag they were written with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 2 | Start threshold: 00 store-and-forward, 01 432 words, 10 256 words, 11 128 words |
| retry_limit | input | 4 | Retries allowed per packet; 0 forces store-and-forward |
| wr_valid | input | 1 | Writer offers a word |
| wr_data | input | 32 | Word to store |
| wr_eop | input | 1 | Word is the last of its packet |
| wr_full | output | 1 | FIFO cannot accept a word |
| rd_ready | input | 1 | Link takes a word this cycle |
| rd_valid | output | 1 | A word is offered to the link |
| rd_data | output | 32 | Offered word |
| rd_eop | output | 1 | Offered word ends the packet |
| tx_busy | output | 1 | A packet attempt is in progress |
| tx_abort | output | 1 | Underrun pulse: current attempt aborted |
| tx_drop | output | 1 | Packet abandoned after its last retry |

## Verification
The hardest situation to reach is the give-up path. Every retry runs in store-and-forward and cannot underrun, so a packet cannot exhaust its retries through the ports alone. The stimulus sets a retry limit of one and lets a 128-word cut-through start underrun. It then changes the threshold field to re-arm cut-through, extends the buffered part to 256 words so the second attempt starts and underruns too, and writes the tail of the packet afterwards to show that it is discarded.

// File: rtl/tx_cut_pkg.sv
package tx_cut_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_SEND = 2'd1,
        ST_DROP = 2'd2
    } txc_state_e;

    typedef struct packed {
        logic        eop;
        logic [31:0] data;
    } txc_word_t;
endpackage

// File: rtl/txc_mem.sv
module txc_mem #(
    parameter int AW = 10
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  tx_cut_pkg::txc_word_t wdata,
    input  logic [AW-1:0]         raddr,
    output tx_cut_pkg::txc_word_t rdata
);
    localparam int DEPTH = 1 << AW;

    tx_cut_pkg::txc_word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/txc_start_decide.sv
module txc_start_decide #(
    parameter int AW     = 10,
    parameter int TH_1K7 = 432,
    parameter int TH_1K  = 256,
    parameter int TH_512 = 128
) (
    input  logic [1:0]  thr_sel,
    input  logic        sf_force,
    input  logic        pkt_complete,
    input  logic [AW:0] level,
    output logic        go
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0] thr_words;
    logic        cut_on;

    always_comb begin
        unique case (thr_sel)
            2'b01:   thr_words = (AW+1)'(TH_1K7);
            2'b10:   thr_words = (AW+1)'(TH_1K);
            2'b11:   thr_words = (AW+1)'(TH_512);
            default: thr_words = (AW+1)'(DEPTH);
        endcase
        cut_on = (thr_sel != 2'b00) && !sf_force;
        go     = pkt_complete || (cut_on && (level >= thr_words));
    end
endmodule

// File: rtl/tx_cut_ctl.sv
module tx_cut_ctl #(
    parameter int AW      = 10,
    parameter int RETRY_W = 4,
    parameter int TH_1K7  = 432,
    parameter int TH_1K   = 256,
    parameter int TH_512  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         thr_sel,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               wr_valid,
    input  logic [31:0]        wr_data,
    input  logic               wr_eop,
    output logic               wr_full,
    input  logic               rd_ready,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               rd_eop,
    output logic               tx_busy,
    output logic               tx_abort,
    output logic               tx_drop
);
    import tx_cut_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    txc_state_e state, state_nx;

    logic [AW:0]        wr_ptr, rd_ptr, pkt_start, eop_cnt, level;
    logic [RETRY_W-1:0] retry_used;
    logic [1:0]         thr_q;
    logic               sticky_sf, sf_force, go;
    logic               nonempty, pop, discard, underrun, done, wr_acc, retry_ok;
    txc_word_t          rd_word, wr_word;

    assign wr_word  = '{eop: wr_eop, data: wr_data};
    assign level    = wr_ptr - pkt_start;
    assign wr_full  = (level == FULL_LVL);
    assign wr_acc   = wr_valid && !wr_full;
    assign nonempty = (rd_ptr != wr_ptr);
    assign pop      = (state == ST_SEND) && nonempty && rd_ready;
    assign underrun = (state == ST_SEND) && !nonempty && rd_ready;
    assign discard  = (state == ST_DROP) && nonempty;
    assign done     = (pop || discard) && rd_word.eop;
    assign retry_ok = (retry_used < retry_limit);
    assign sf_force = sticky_sf || (retry_limit == '0);

    txc_mem #(.AW(AW)) u_mem (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_word),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_word)
    );

    txc_start_decide #(
        .AW(AW), .TH_1K7(TH_1K7), .TH_1K(TH_1K), .TH_512(TH_512)
    ) u_decide (
        .thr_sel      (thr_sel),
        .sf_force     (sf_force),
        .pkt_complete (eop_cnt != '0),
        .level        (level),
        .go           (go)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // transitions: start, finish, retry, give-up, flush
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (go) state_nx = ST_SEND;
            ST_SEND: begin
                if (done)          state_nx = ST_WAIT;
                else if (underrun) state_nx = retry_ok ? ST_WAIT : ST_DROP;
            end
            ST_DROP: if (done) state_nx = ST_WAIT;
            default: state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = (state == ST_SEND) && nonempty;
        rd_data  = rd_word.data;
        rd_eop   = rd_word.eop;
        tx_busy  = (state == ST_SEND);
        tx_abort = underrun;
        tx_drop  = underrun && !retry_ok;
    end

    // pointers and packet bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            pkt_start  <= '0;
            eop_cnt    <= '0;
            retry_used <= '0;
            sticky_sf  <= 1'b0;
            thr_q      <= 2'b00;
        end else begin
            thr_q <= thr_sel;
            if (wr_acc) wr_ptr <= wr_ptr + 1'b1;

            if (underrun)            rd_ptr <= pkt_start;
            else if (pop || discard) rd_ptr <= rd_ptr + 1'b1;

            if (done) pkt_start <= rd_ptr + 1'b1;

            eop_cnt <= eop_cnt + (AW+1)'(wr_acc && wr_eop) - (AW+1)'(done);

            if (done)                      retry_used <= '0;
            else if (underrun && retry_ok) retry_used <= retry_used + 1'b1;

            if (underrun)              sticky_sf <= 1'b1;
            else if (thr_sel != thr_q) sticky_sf <= 1'b0;
        end
    end
endmodule

// File: rtl/txc_chk.sv
module txc_chk #(
    parameter int AW      = 10,
    parameter int RETRY_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input tx_cut_pkg::txc_state_e state,
    input logic [1:0]             thr_sel,
    input logic [RETRY_W-1:0]     retry_limit,
    input logic [AW:0]            eop_cnt,
    input logic [AW:0]            rd_ptr,
    input logic [AW:0]            wr_ptr,
    input logic [AW:0]            pkt_start,
    input logic                   sticky_sf,
    input logic                   tx_abort,
    input logic                   tx_drop,
    input logic                   tx_busy,
    input logic                   wr_full,
    input logic                   wr_valid
);
    import tx_cut_pkg::*;

    AST_SF_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && thr_sel == 2'b00 && eop_cnt == '0) |=> state != ST_SEND); // R2

    AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> (rd_ptr == $past(pkt_start)) && !tx_busy); // R5

    AST_STICKY_WAITS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && sticky_sf && eop_cnt == '0) |=> state != ST_SEND); // R6

    AST_ZERO_RETRY_SF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && retry_limit == '0 && eop_cnt == '0) |=> state != ST_SEND); // R8

    AST_GIVEUP_TO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> state == ST_DROP); // R9

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && wr_valid) |=> wr_ptr == $past(wr_ptr)); // R10
endmodule

bind tx_cut_ctl txc_chk #(.AW(AW), .RETRY_W(RETRY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .thr_sel     (thr_sel),
    .retry_limit (retry_limit),
    .eop_cnt     (eop_cnt),
    .rd_ptr      (rd_ptr),
    .wr_ptr      (wr_ptr),
    .pkt_start   (pkt_start),
    .sticky_sf   (sticky_sf),
    .tx_abort    (tx_abort),
    .tx_drop     (tx_drop),
    .tx_busy     (tx_busy),
    .wr_full     (wr_full),
    .wr_valid    (wr_valid)
);

// File: tb/sim_tx_cut_ctl.sv
`timescale 1ns/1ps
module sim_tx_cut_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_sel = 2'b00;
    logic [3:0]  retry_limit = 4'd3;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_eop = 1'b0;
    logic        rd_ready = 1'b0;
    logic        wr_full, rd_valid, rd_eop, tx_busy, tx_abort, tx_drop;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    int abort_cnt = 0;
    int drop_cnt = 0;
    int pos = 0;
    logic [32:0] exp_q[$];

    always #2 clk = ~clk;

    tx_cut_ctl u0 (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .retry_limit(retry_limit),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop), .wr_full(wr_full),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eop(rd_eop),
        .tx_busy(tx_busy), .tx_abort(tx_abort), .tx_drop(tx_drop)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard compare at negedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && rd_ready) begin
                if (pos >= exp_q.size()) begin
                    chk(0, "R11/R9 unexpected word", {rd_eop, rd_data}, 0);
                end else begin
                    chk({rd_eop, rd_data} == exp_q[pos], "R11 word",
                        {rd_eop, rd_data}, exp_q[pos]);
                    if (rd_eop) begin
                        for (int k = 0; k <= pos; k++) void'(exp_q.pop_front());
                        pos = 0;
                    end else pos++;
                end
            end
            if (tx_abort) begin
                abort_cnt++;
                pos = 0;
            end
            if (tx_drop) begin
                drop_cnt++;
                while (exp_q.size() > 0) begin
                    logic [32:0] w;
                    w = exp_q.pop_front();
                    if (w[32]) break;
                end
                pos = 0;
            end
        end
    end

    // driver: queue a full packet as expected
    task automatic push_pkt(input int id, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back({(i == n-1), 32'(id << 16 | i)});
    endtask

    task automatic wr(input logic [31:0] d, input logic e);
        wr_valid = 1'b1; wr_data = d; wr_eop = e;
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic send_words(input int id, input int first, input int last, input int n);
        for (int i = first; i <= last; i++) wr(32'(id << 16 | i), (i == n-1));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_empty(input string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) idle(1);
        idle(3);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic chk_busy_at_neg(input logic exp, input string req);
        @(negedge clk);
        chk(tx_busy == exp, req, tx_busy, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        chk(!wr_full && !rd_valid && !tx_busy && !tx_abort && !tx_drop, "R1 reset",
            {wr_full, rd_valid, tx_busy, tx_abort, tx_drop}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd_ready = 1'b1;
        idle(2);

        // R2: store-and-forward default
        push_pkt(1, 200);
        send_words(1, 0, 198, 200);
        idle(3);
        chk_busy_at_neg(1'b0, "R2 no start before eop");
        send_words(1, 199, 199, 200);
        wait_empty("R2 packet delivered");

        // R3 / R5 / R6: cut-through at 128 words, underrun, store-and-forward retry
        thr_sel = 2'b11;
        idle(2);
        push_pkt(2, 200);
        send_words(2, 0, 126, 200);
        idle(2);
        chk_busy_at_neg(1'b0, "R3 127 words below level");
        send_words(2, 127, 127, 200);
        @(negedge clk);
        chk(tx_busy == 1'b0, "R3 not yet started", tx_busy, 0);
        @(posedge clk); #1;
        chk_busy_at_neg(1'b1, "R3 start at 128 words");
        idle(140);
        chk(abort_cnt == 1, "R5 abort on underrun", abort_cnt, 1);
        chk_busy_at_neg(1'b0, "R5 busy dropped");
        send_words(2, 128, 198, 200);
        idle(3);
        chk_busy_at_neg(1'b0, "R6 retry waits for eop");
        send_words(2, 199, 199, 200);
        wait_empty("R5 resend from first word");

        // R7: fallback persists
        push_pkt(3, 150);
        send_words(3, 0, 148, 150);
        idle(3);
        chk_busy_at_neg(1'b0, "R7 sticky store-and-forward");
        send_words(3, 149, 149, 150);
        wait_empty("R7 packet delivered");

        // R4: short packet below 432-word level
        thr_sel = 2'b01;
        idle(2);
        push_pkt(4, 10);
        send_words(4, 0, 9, 10);
        idle(20);
        chk(exp_q.size() == 0, "R4 short packet started", exp_q.size(), 0);

        // R9: retry exhaustion
        thr_sel = 2'b11;
        retry_limit = 4'd1;
        idle(2);
        push_pkt(5, 300);
        send_words(5, 0, 127, 300);
        idle(140);
        chk(abort_cnt == 2, "R5 first attempt aborted", abort_cnt, 2);
        thr_sel = 2'b10;
        idle(2);
        send_words(5, 128, 255, 300);
        idle(300);
        chk(abort_cnt == 3, "R9 abort on last underrun", abort_cnt, 3);
        chk(drop_cnt == 1, "R9 drop pulse", drop_cnt, 1);
        send_words(5, 256, 299, 300);
        idle(5);
        chk_busy_at_neg(1'b0, "R9 tail discarded");
        push_pkt(6, 5);
        send_words(6, 0, 4, 5);
        wait_empty("R9 next packet intact");

        // R8: zero retries forces store-and-forward
        retry_limit = 4'd0;
        thr_sel = 2'b11;
        idle(2);
        push_pkt(7, 200);
        send_words(7, 0, 198, 200);
        idle(3);
        chk_busy_at_neg(1'b0, "R8 no cut-through");
        send_words(7, 199, 199, 200);
        wait_empty("R8 packet delivered");

        // R10: full
        rd_ready = 1'b0;
        thr_sel = 2'b00;
        retry_limit = 4'd3;
        idle(2);
        for (int p = 0; p < 128; p++) begin
            push_pkt(16 + p, 8);
            send_words(16 + p, 0, 7, 8);
        end
        @(negedge clk);
        chk(wr_full == 1'b1, "R10 full at 1024 words", wr_full, 1);
        @(posedge clk); #1;
        wr(32'hDEAD_BEEF, 1'b1);
        @(negedge clk);
        chk(wr_full == 1'b1, "R10 still full", wr_full, 1);
        @(posedge clk); #1;
        rd_ready = 1'b1;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk(wr_full == 1'b1, "R10 full until packet done", wr_full, 1);
        @(posedge clk);
        @(negedge clk);
        chk(wr_full == 1'b0, "R10 full clears", wr_full, 0);
        @(posedge clk); #1;
        wait_empty("R10 R11 all delivered");
        chk(abort_cnt == 3, "R11 no extra abort", abort_cnt, 3);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule